// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog timer that counts a slow tick input which acts as a clock enable, and that acts when software stops restarting it. On time-out it can raise an interrupt flag, issue a one-cycle system reset pulse, or do both in turn: interrupt first and reset on the next time-out. Software reaches its control bits through a single-byte write port with a read-back, and restarts the count with a kick input.

Changes that would weaken the watchdog need a two-step protected sequence. Such changes are clearing the enable or moving its period. The first write sets change-enable together with enable. A second write, with change-enable low, must land within a short window after the first. Unguarded writes may only make the watchdog stricter. A reset flag records that the watchdog fired a reset. The watchdog's own control state survives that reset pulse, so it stays enabled. While the flag is set, the enable cannot be dropped.

Top module: `wdog_guard`

## Requirements
- R1: After reset, `ctrl_q` reads 0x00 and `irq`, `rst_pulse` and `rst_flag` are all low.
- R2: Control byte fields are bit 0 enable, bit 1 interrupt enable, bit 2 change-enable (always reads 0), bit 3 reads 0, and bits 7:4 period select. An unguarded write may set enable and may write interrupt enable. It cannot clear enable or change the period select.
- R3: A write with bits 2 and 0 both set opens the window. It sets enable, writes interrupt enable, and leaves the period unchanged. A write with bit 2 clear on any of the next 4 clock cycles applies its enable and period select and closes the window.
- R4: A write with bit 2 clear that arrives 5 or more cycles after the opening write is treated as an unguarded write.
- R5: The time-out period is 2^(BASE_EXP+n) ticks for period select n up to 9. Codes 10 to 15 give the same period as 9, and the raw code still reads back.
- R6: With interrupt enable set and enable clear (interrupt mode), each time-out sets `irq` until `irq_ack`. No reset pulse is produced, and the count carries on.
- R7: With enable set and interrupt enable clear (reset mode), a time-out gives a `rst_pulse` exactly one clock cycle long and sets `rst_flag`, and enable stays set.
- R8: With both bits set (combined mode), the first time-out sets `irq` and clears interrupt enable with no reset. The following time-out gives the reset pulse.
- R9: While `rst_flag` is set, even a protected write cannot clear enable. `clr_flag` clears the flag, after which the protected clear works.
- R10: `kick` restarts the count from zero, and so does a protected write of the period.
- R11: The count advances only on clock cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Watchdog tick, one count per high cycle |
| kick | input | 1 | Restart the count |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte to write |
| clr_flag | input | 1 | Clear the watchdog reset flag |
| irq_ack | input | 1 | Clear the interrupt flag |
| ctrl_q | output | 8 | Control byte read-back |
| irq | output | 1 | Interrupt flag |
| rst_pulse | output | 1 | One-cycle system reset request |
| rst_flag | output | 1 | Watchdog caused a reset |

## Verification
A small base exponent is used so that all sixteen period codes can be swept. Each code's measured time-out must equal a power of two, which shows the exponent offset and the saturation above code 9. The second write of the unlock sequence is placed at gaps of 4 and 5 cycles after the first. This pins the window edge to the exact cycle, because the read-back differs between a guarded and an unguarded outcome. The three modes are each run through two successive time-outs, which separates one-shot interrupt, repeated interrupt and reset behaviour. A tick pattern of one in three cycles and mid-count kicks show that the count follows ticks and not clocks, and that it restarts from zero.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef struct packed {
    logic [3:0] psel;
    logic       rsv;
    logic       ce;
    logic       ie;
    logic       en;
  } wdg_ctrl_t;

endpackage

// File: rtl/wdg_window.sv
module wdg_window #(
  parameter int WIN_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic wr_any,
  output logic win_open
);
  localparam int WIN_W = $clog2(WIN_CYC + 1);

  logic [WIN_W-1:0] win_cnt, win_cnt_n;

  always_comb begin
    win_cnt_n = win_cnt;
    if (open_req)           win_cnt_n = WIN_W'(WIN_CYC);
    else if (wr_any)        win_cnt_n = '0;
    else if (win_cnt != '0) win_cnt_n = win_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_cnt <= '0;
    else        win_cnt <= win_cnt_n;
  end

  assign win_open = (win_cnt != '0);
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int PSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              win_open,
  input  logic              rst_flag,
  input  logic              ie_clr,
  output logic              open_req,
  output logic              psel_load,
  output logic              en,
  output logic              ie,
  output logic [PSEL_W-1:0] psel
);
  wdg_ctrl_t        d;
  logic             en_n, ie_n;
  logic [PSEL_W-1:0] psel_n;

  assign d         = wdg_ctrl_t'(wr_data);
  assign open_req  = wr_en & d.ce & d.en;
  assign psel_load = wr_en & win_open & ~d.ce;

  always_comb begin
    en_n   = en;
    ie_n   = ie;
    psel_n = psel;
    if (wr_en) begin
      ie_n = d.ie;
      if (psel_load) begin
        en_n   = d.en | rst_flag;
        psel_n = PSEL_W'(d.psel);
      end else begin
        en_n   = en | d.en;
      end
    end
    if (ie_clr) ie_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      ie   <= 1'b0;
      psel <= '0;
    end else begin
      en   <= en_n;
      ie   <= ie_n;
      psel <= psel_n;
    end
  end
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
  parameter int BASE_EXP = 11,
  parameter int PSEL_MAX = 9,
  parameter int PSEL_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              kick,
  input  logic              restart,
  input  logic              run,
  input  logic [PSEL_W-1:0] psel,
  output logic              timeout
);
  localparam int CNT_W = BASE_EXP + PSEL_MAX;

  logic [PSEL_W-1:0] psel_sat;
  logic [CNT_W-1:0]  lim_m1;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic              hit;

  assign psel_sat = (psel > PSEL_W'(PSEL_MAX)) ? PSEL_W'(PSEL_MAX) : psel;
  assign lim_m1   = {CNT_W{1'b1}} >> (PSEL_W'(PSEL_MAX) - psel_sat);
  assign hit      = run & tick & ~kick & ~restart & (cnt == lim_m1);
  assign timeout  = hit;

  always_comb begin
    cnt_n = cnt;
    if (!run || kick || restart) cnt_n = '0;
    else if (tick)               cnt_n = hit ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/wdg_events.sv
module wdg_events (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout,
  input  logic en,
  input  logic ie,
  input  logic irq_ack,
  input  logic clr_flag,
  output logic ie_clr,
  output logic irq_flag,
  output logic rst_flag,
  output logic rst_pulse
);
  logic to_irq, to_rst;
  logic irq_flag_n, rst_flag_n;

  assign to_irq = timeout & ie;
  assign to_rst = timeout & en & ~ie;
  assign ie_clr = timeout & en & ie;

  always_comb begin
    irq_flag_n = irq_flag;
    if (to_irq)       irq_flag_n = 1'b1;
    else if (irq_ack) irq_flag_n = 1'b0;
    rst_flag_n = rst_flag;
    if (to_rst)        rst_flag_n = 1'b1;
    else if (clr_flag) rst_flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag  <= 1'b0;
      rst_flag  <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      irq_flag  <= irq_flag_n;
      rst_flag  <= rst_flag_n;
      rst_pulse <= to_rst;
    end
  end
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int BASE_EXP = 11,
  parameter int PSEL_MAX = 9,
  parameter int WIN_CYC  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       kick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       clr_flag,
  input  logic       irq_ack,
  output logic [7:0] ctrl_q,
  output logic       irq,
  output logic       rst_pulse,
  output logic       rst_flag
);
  localparam int PSEL_W = 4;

  logic              win_open, open_req, psel_load;
  logic              en, ie, ie_clr, timeout;
  logic [PSEL_W-1:0] psel;

  wdg_window #(.WIN_CYC(WIN_CYC)) u_window (
    .clk(clk), .rst_n(rst_n), .open_req(open_req), .wr_any(wr_en),
    .win_open(win_open)
  );

  wdg_ctrl #(.PSEL_W(PSEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .win_open(win_open), .rst_flag(rst_flag), .ie_clr(ie_clr),
    .open_req(open_req), .psel_load(psel_load),
    .en(en), .ie(ie), .psel(psel)
  );

  wdg_timer #(.BASE_EXP(BASE_EXP), .PSEL_MAX(PSEL_MAX), .PSEL_W(PSEL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick),
    .restart(psel_load), .run(en | ie), .psel(psel), .timeout(timeout)
  );

  wdg_events u_events (
    .clk(clk), .rst_n(rst_n), .timeout(timeout), .en(en), .ie(ie),
    .irq_ack(irq_ack), .clr_flag(clr_flag), .ie_clr(ie_clr),
    .irq_flag(irq), .rst_flag(rst_flag), .rst_pulse(rst_pulse)
  );

  assign ctrl_q = {psel, 2'b00, ie, en};
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] ctrl_q,
  input logic       irq,
  input logic       rst_pulse,
  input logic       rst_flag
);
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);

  assert_pulse_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> (rst_flag && ctrl_q[0]));

  assert_flag_holds_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_flag |-> ctrl_q[0]);

  assert_reset_mode_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> ($past(ctrl_q[0]) && !$past(ctrl_q[1])));

  assert_combined_drops_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && $past(ctrl_q[0])) |-> !ctrl_q[1]);

  assert_period_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(ctrl_q[7:4]));

  assert_en_clear_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q[0]) |-> $past(wr_en));
endmodule

bind wdog_guard wdog_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctrl_q(ctrl_q),
  .irq(irq), .rst_pulse(rst_pulse), .rst_flag(rst_flag)
);

// File: tb/wdog_guard_bench.sv
module wdog_guard_bench;
  localparam int BASE = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       kick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       clr_flag = 1'b0;
  logic       irq_ack = 1'b0;
  logic [7:0] ctrl_q;
  logic       irq, rst_pulse, rst_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;

  always #2 clk = ~clk;

  wdog_guard #(.BASE_EXP(BASE)) u_wdog_guard (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick),
    .wr_en(wr_en), .wr_data(wr_data), .clr_flag(clr_flag), .irq_ack(irq_ack),
    .ctrl_q(ctrl_q), .irq(irq), .rst_pulse(rst_pulse), .rst_flag(rst_flag)
  );

  always @(negedge clk) if (rst_pulse) pulses++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog all-reqs actual %0d expected <150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; kick = 1'b0; clr_flag = 1'b0; irq_ack = 1'b0; tick = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pulses = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic guarded(input logic [7:0] d);
    wr(8'h07);
    wr(d);
  endtask

  task automatic pulse_kick();
    kick = 1'b1; @(negedge clk); kick = 1'b0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic wait_sig(input int which, output int k);
    k = 0;
    while (((which == 0) ? irq : rst_pulse) == 1'b0 && k < 5000) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    int k;
    do_reset();
    // R1 reset state
    check("R1 ctrl", ctrl_q, 0);
    check("R1 irq", irq, 0);
    check("R1 pulse", rst_pulse, 0);
    check("R1 flag", rst_flag, 0);

    // R2 unguarded writes
    kick = 1'b1;
    wr(8'h02); check("R2 set ie", ctrl_q, 8'h02);
    wr(8'h30); check("R2 period locked", ctrl_q, 8'h00);
    wr(8'h01); check("R2 set en", ctrl_q, 8'h01);
    wr(8'h00); check("R2 en clear ignored", ctrl_q, 8'h01);

    // R3 opening write, change-enable reads zero
    do_reset();
    kick = 1'b1;
    wr(8'h07); check("R3 open readback", ctrl_q, 8'h03);
    repeat (3) @(negedge clk);
    wr(8'h50); check("R3 last window cycle", ctrl_q, 8'h50);

    // R4 window expired
    do_reset();
    kick = 1'b1;
    wr(8'h07);
    repeat (4) @(negedge clk);
    wr(8'h50); check("R4 late write unguarded", ctrl_q, 8'h01);
    kick = 1'b0;

    // R5 period sweep in interrupt mode
    for (int n = 0; n < 16; n++) begin
      int e;
      e = (n > 9) ? 9 : n;
      do_reset();
      guarded(8'((n << 4) | 2));
      check("R5 readback", ctrl_q, (n << 4) | 2);
      wait_sig(0, k);
      check("R5 period", k, 1 << (BASE + e));
      check("R6 no pulse", pulses, 0);
      if (n == 0) begin
        check("R6 ie kept", ctrl_q[1], 1);
        pulse_ack();
        check("R6 ack", irq, 0);
        wait_sig(0, k);
        check("R6 repeat", k, (1 << BASE) - 1);
      end
    end

    // R7 reset mode, R9 flag protection
    do_reset();
    guarded(8'h31);
    wait_sig(1, k);
    check("R7 period", k, 32);
    check("R7 flag", rst_flag, 1);
    @(negedge clk);
    check("R7 one cycle", rst_pulse, 0);
    check("R7 en kept", ctrl_q[0], 1);
    guarded(8'h30);
    check("R9 en held by flag", ctrl_q, 8'h31);
    clr_flag = 1'b1; @(negedge clk); clr_flag = 1'b0;
    check("R9 flag cleared", rst_flag, 0);
    guarded(8'h30);
    check("R9 en cleared", ctrl_q, 8'h30);

    // R8 combined mode
    do_reset();
    guarded(8'h13);
    wait_sig(0, k);
    check("R8 first period", k, 8);
    check("R8 ie cleared", ctrl_q[1], 0);
    check("R8 no reset yet", pulses, 0);
    wait_sig(1, k);
    check("R8 second period", k, 8);
    check("R8 flag", rst_flag, 1);

    // R10 kick and period rewrite
    do_reset();
    guarded(8'h22);
    repeat (10) @(negedge clk);
    pulse_kick();
    wait_sig(0, k);
    check("R10 kick restart", k, 16);
    pulse_ack();
    repeat (5) @(negedge clk);
    guarded(8'h22);
    wait_sig(0, k);
    check("R10 rewrite restart", k, 16);

    // R11 tick gating
    do_reset();
    tick = 1'b0;
    guarded(8'h02);
    k = 0;
    while (!irq && k < 200) begin
      tick = ((k + 1) % 3 == 0);
      @(negedge clk);
      k++;
    end
    tick = 1'b1;
    check("R11 ticks only", k, 12);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule